// File: doc/BRIEF.md
# Multicast Hash Destination Filter

This block decides, from the 48-bit destination address at the head of a received Ethernet frame, whether the frame is kept. The address arrives as a byte stream, one octet per cycle, and a reflected CRC-32 is accumulated over the six octets. The CRC is complemented and bit-reversed. Its top bits then index a hash table of 64, 128 or 256 bits, and the table size is fixed by the `SIZE_CODE` build parameter.

A small register port programs the table words and a mode register. Every register write carries a bit mask, so software can change individual mode bits without a read-modify-write. Promiscuous operation passes every frame. Pass-all-multicast passes every group-addressed frame. Hash filtering passes a multicast frame only when its table bit is set. The all-ones broadcast address passes unless broadcast is disabled. Frames whose destination is not group-addressed are not judged here: they are flagged as unicast for a later stage.

Top module: `mc_hash_filter`

## Requirements
- R1: After reset every table word and every mode bit read 0, `dec_valid` is 0, and a multicast frame is dropped.
- R2: The register at offset 0x04 is read-only. Bits 25:24 hold `SIZE_CODE`, where 1, 2 and 3 give 64, 128 and 256 table bits. Every other bit reads 0, and writes to this register change nothing.
- R3: The table is N/32 words with N = 32 << `SIZE_CODE`. Word i sits at offset 0x10 + 4*i. A write changes only the bits where `reg_wmask` is 1, and those bits take `reg_wdata`.
- R4: The mode register at offset 0x08 holds: bit 0 promiscuous, bit 1 pass-all-multicast, bit 2 hash enable, bit 3 pass-control-frames, bit 4 broadcast disable. A write changes only the masked bits. Bits 31:5 read 0.
- R5: The hash index is formed in four steps. A CRC-32 with reflected polynomial 0xEDB88320 and an all-ones start value runs over the six octets in arrival order, least significant bit of each octet first. The result is complemented and bit-reversed. The index is the top log2(N) bits of that value. Index bits above bit 4 pick the table word and the low five bits pick the bit within it. In hash mode a non-broadcast multicast frame passes exactly when that bit is 1.
- R6: `dec_valid` pulses for one cycle on the cycle after the sixth octet. An octet with `in_sof` high starts a new address. Octets after the sixth, and cycles with `in_valid` low, are ignored.
- R7: With promiscuous set, every frame is accepted and `dec_unicast` is 0.
- R8: With pass-all-multicast set, every multicast frame passes whatever the table holds. This gives the same result as hash mode with an all-ones table.
- R9: A frame whose first octet has bit 0 clear, when promiscuous is off, gives `dec_accept`=0 and `dec_unicast`=1.
- R10: The broadcast address passes when promiscuous is off and broadcast disable is 0. When broadcast disable is 1 it is dropped, even if pass-all-multicast is set. Promiscuous still passes it.
- R11: A register write in the same cycle as the sixth octet takes effect only for later frames. That frame's decision uses the contents from before the write.
- R12: Offsets that are not mapped read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address octet valid |
| in_sof | input | 1 | Octet is the first of a frame |
| in_byte | input | 8 | Address octet |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Per-bit write enable |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame passes |
| dec_unicast | output | 1 | Frame is not group-addressed and is left to a later stage |

## Verification
A table or mode write and a filter decision can fall in the same cycle. To provoke this, the bench raises the register write strobe on the same cycle as the sixth address octet. The hash table starts all zeros with hash mode on, and the write fills the table with ones. The decision for that frame must be a drop. The next frame with the same address must pass, and a read of the table must show the new contents.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [7:0]  OFS_FEATURE   = 8'h04;
  localparam logic [7:0]  OFS_MODE      = 8'h08;
  localparam logic [7:0]  OFS_TABLE     = 8'h10;
  localparam int          MODE_BITS     = 5;

  typedef struct packed {
    logic bc_off;     // bit 4
    logic pass_ctl;   // bit 3
    logic hash_en;    // bit 2
    logic all_mc;     // bit 1
    logic promisc;    // bit 0
  } mode_t;

  // one octet of the reflected CRC, LSB first
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // top 8 bits of bitrev(~crc): bit 7 comes from crc bit 0
  function automatic logic [7:0] hash_top8(input logic [31:0] c);
    logic [31:0] inv;
    logic [7:0]  r;
    inv = ~c;
    for (int i = 0; i < 8; i++) r[7-i] = inv[i];
    return r;
  endfunction
endpackage

// File: rtl/mhf_crc_acc.sv
module mhf_crc_acc
  import mhf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic [7:0]  in_byte,
  output logic [31:0] crc_nx,
  output logic        frame_mc,
  output logic        frame_bc,
  output logic        sixth_byte
);
  localparam logic [2:0] IDLE = 3'd6;

  logic [2:0]  cnt_q;
  logic [31:0] crc_q;
  logic        mc_q, bc_q;
  logic        start, cont;

  assign start      = in_valid && in_sof;
  assign cont       = in_valid && !in_sof && (cnt_q != 3'd0) && (cnt_q < IDLE);
  assign sixth_byte = cont && (cnt_q == 3'd5);
  assign crc_nx     = crc_step_byte(start ? 32'hFFFF_FFFF : crc_q, in_byte);
  assign frame_mc   = start ? in_byte[0] : mc_q;
  assign frame_bc   = (start || bc_q) && (in_byte == 8'hFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= IDLE;
      crc_q <= '1;
      mc_q  <= 1'b0;
      bc_q  <= 1'b0;
    end else if (start || cont) begin
      cnt_q <= start ? 3'd1 : cnt_q + 3'd1;
      crc_q <= crc_nx;
      mc_q  <= frame_mc;
      bc_q  <= frame_bc;
    end
  end
endmodule

// File: rtl/mhf_regs.sv
module mhf_regs
  import mhf_pkg::*;
#(
  parameter int SIZE_CODE = 1
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [7:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  input  logic [31:0]  reg_wmask,
  output logic [31:0]  reg_rdata,
  output mode_t        mode,
  output logic [(32<<SIZE_CODE)-1:0] table_flat
);
  localparam int WORDS = 1 << SIZE_CODE;

  logic [31:0] words [WORDS];
  logic [MODE_BITS-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (reg_we && reg_addr == OFS_MODE)
      mode_q <= (mode_q & ~reg_wmask[MODE_BITS-1:0]) | (reg_wdata[MODE_BITS-1:0] & reg_wmask[MODE_BITS-1:0]);
  end
  assign mode = mode_t'(mode_q);

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam logic [7:0] OFS = OFS_TABLE + 8'(4 * i);
    always_ff @(posedge clk) begin
      if (!rst_n) words[i] <= '0;
      else if (reg_we && reg_addr == OFS)
        words[i] <= (words[i] & ~reg_wmask) | (reg_wdata & reg_wmask);
    end
    assign table_flat[32*i +: 32] = words[i];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_FEATURE) reg_rdata[25:24] = 2'(SIZE_CODE);
    else if (reg_addr == OFS_MODE) reg_rdata[MODE_BITS-1:0] = mode_q;
    for (int i = 0; i < WORDS; i++)
      if (reg_addr == OFS_TABLE + 8'(4 * i)) reg_rdata = words[i];
  end
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
  import mhf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  logic  frame_mc,
  input  logic  frame_bc,
  input  logic  table_hit,
  input  mode_t mode,
  output logic  dec_valid,
  output logic  dec_accept,
  output logic  dec_unicast
);
  logic acc_nx, uc_nx;

  always_comb begin
    uc_nx = 1'b0;
    if (mode.promisc)     acc_nx = 1'b1;
    else if (!frame_mc) begin
      acc_nx = 1'b0;
      uc_nx  = 1'b1;
    end
    else if (frame_bc)    acc_nx = !mode.bc_off;
    else if (mode.all_mc) acc_nx = 1'b1;
    else if (mode.hash_en) acc_nx = table_hit;
    else                  acc_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_accept  <= 1'b0;
      dec_unicast <= 1'b0;
    end else begin
      dec_valid   <= fire;
      dec_accept  <= fire && acc_nx;
      dec_unicast <= fire && uc_nx;
    end
  end
endmodule

// File: rtl/mc_hash_filter.sv
module mc_hash_filter
  import mhf_pkg::*;
#(
  parameter int SIZE_CODE = 1
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic [7:0]  in_byte,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic [31:0] reg_wmask,
  output logic [31:0] reg_rdata,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic        dec_unicast
);
  localparam int NBITS = 32 << SIZE_CODE;
  localparam int IDXW  = 5 + SIZE_CODE;

  logic [31:0]      crc_nx;
  logic             frame_mc, frame_bc, sixth_byte, table_hit;
  logic [7:0]       top8;
  logic [IDXW-1:0]  hash_idx;
  logic [NBITS-1:0] table_flat;
  mode_t            mode;

  mhf_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_byte(in_byte),
    .crc_nx(crc_nx), .frame_mc(frame_mc), .frame_bc(frame_bc), .sixth_byte(sixth_byte)
  );

  mhf_regs #(.SIZE_CODE(SIZE_CODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wmask(reg_wmask), .reg_rdata(reg_rdata), .mode(mode), .table_flat(table_flat)
  );

  assign top8      = hash_top8(crc_nx);
  assign hash_idx  = top8[7 -: IDXW];
  assign table_hit = table_flat[hash_idx];

  mhf_decide u_dec (
    .clk(clk), .rst_n(rst_n), .fire(sixth_byte), .frame_mc(frame_mc), .frame_bc(frame_bc),
    .table_hit(table_hit), .mode(mode),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_unicast(dec_unicast)
  );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int SIZE_CODE = 1
)(
  input logic        clk,
  input logic        rst_n,
  input logic        sixth_byte,
  input logic        frame_mc,
  input logic        frame_bc,
  input logic        table_hit,
  input logic [4:0]  mode_bits,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic        dec_valid,
  input logic        dec_accept,
  input logic        dec_unicast
);
  a_r6_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sixth_byte |=> dec_valid);
  a_r6_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(sixth_byte));
  a_r7_promisc_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (sixth_byte && mode_bits[0]) |=> (dec_accept && !dec_unicast));
  a_r9_unicast_drop: assert property (@(posedge clk) disable iff (!rst_n)
    dec_unicast |-> (dec_valid && !dec_accept));
  a_r5_hash_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sixth_byte && mode_bits[2:0] == 3'b100 && frame_mc && !frame_bc) |=> (dec_accept == $past(table_hit)));
  a_r10_bc_block: assert property (@(posedge clk) disable iff (!rst_n)
    (sixth_byte && frame_bc && mode_bits[4] && !mode_bits[0]) |=> !dec_accept);
  a_r2_feature: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h04) |-> (reg_rdata == {6'b0, 2'(SIZE_CODE), 24'b0}));
endmodule

bind mc_hash_filter mhf_checker #(.SIZE_CODE(SIZE_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sixth_byte(sixth_byte), .frame_mc(frame_mc), .frame_bc(frame_bc),
  .table_hit(table_hit), .mode_bits(mode), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_unicast(dec_unicast)
);

// File: tb/mc_hash_filter_test.sv
module mc_hash_filter_test;
  localparam int SC    = 1;
  localparam int WORDS = 1 << SC;
  localparam int IDXW  = 5 + SC;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, reg_we = 0;
  logic [7:0]  in_byte = 0, reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_wmask = 0;
  logic [31:0] reg_rdata;
  logic dec_valid, dec_accept, dec_unicast;
  int checks = 0, fails = 0;
  logic [31:0] shadow [WORDS];

  always #5 clk = ~clk;

  mc_hash_filter #(.SIZE_CODE(SC)) uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent form: forward polynomial, non-reflected register
  function automatic int bench_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] oct = a[47-8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb = c[31] ^ oct[j];
        c = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    end
    c = ~c;
    return int'(c >> (32 - IDXW));
  endfunction

  function automatic bit tbl_bit(input int idx);
    return shadow[idx / 32][idx % 32];
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [31:0] m);
    reg_we = 1; reg_addr = a; reg_wdata = d; reg_wmask = m;
    @(negedge clk);
    reg_we = 0; reg_wmask = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    reg_addr = a; #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic fill_table(input logic [31:0] v);
    for (int i = 0; i < WORDS; i++) begin
      wr(8'h10 + 8'(4*i), v, 32'hFFFF_FFFF);
      shadow[i] = v;
    end
  endtask

  task automatic send(input logic [47:0] a, input bit acc, input bit uc, input string req);
    for (int k = 0; k < 6; k++) begin
      in_valid = 1; in_sof = (k == 0); in_byte = a[47-8*k -: 8];
      @(negedge clk);
    end
    in_valid = 0; in_sof = 0;
    chk(dec_valid == 1'b1, req, 32'(dec_valid), 32'd1);
    chk({dec_accept, dec_unicast} == {acc, uc}, req, 32'({dec_accept, dec_unicast}), 32'({acc, uc}));
  endtask

  task automatic finish_report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete");
    finish_report();
  end

  initial begin
    logic [47:0] a;
    for (int i = 0; i < WORDS; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(dec_valid == 0, "R1", 32'(dec_valid), 0);
    rd(8'h08, 0, "R1");
    for (int i = 0; i < WORDS; i++) rd(8'h10 + 8'(4*i), 0, "R1");
    send(48'h01005E000001, 0, 0, "R1");

    // R2 feature register
    rd(8'h04, 32'(SC) << 24, "R2");
    wr(8'h04, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(8'h04, 32'(SC) << 24, "R2");

    // R12 unmapped offsets
    wr(8'h40, 32'h1234_5678, 32'hFFFF_FFFF);
    rd(8'h40, 0, "R12");
    rd(8'h0C, 0, "R12");
    rd(8'h08, 0, "R12");

    // R4 masked mode writes
    wr(8'h08, 32'hFFFF_FFFF, 32'h4);
    rd(8'h08, 32'h4, "R4");
    wr(8'h08, 32'h0, 32'h1);
    rd(8'h08, 32'h4, "R4");
    wr(8'h08, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(8'h08, 32'h1F, "R4");
    wr(8'h08, 32'h0, 32'hFFFF_FFFF);

    // R3 masked table write
    wr(8'h10, 32'hA5A5_A5A5, 32'hFFFF_0000);
    rd(8'h10, 32'hA5A5_0000, "R3");
    wr(8'h10 + 8'(4*(WORDS-1)), 32'h0F0F_0F0F, 32'h00FF_FF00);
    rd(8'h10 + 8'(4*(WORDS-1)), (WORDS == 1) ? 32'hA50F_0F00 : 32'h000F_0F00, "R3");

    // R5 hash sweep over table patterns
    wr(8'h08, 32'h4, 32'hFFFF_FFFF);
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < WORDS; i++) begin
        logic [31:0] v = 32'h9E37_79B9 * 32'(p * 7 + i + 1);
        wr(8'h10 + 8'(4*i), v, 32'hFFFF_FFFF);
        shadow[i] = v;
      end
      for (int k = 0; k < 256; k++) begin
        a = {8'h01, 8'h00, 8'h5E, 8'h00, 8'(k * 3), 8'(k)};
        send(a, tbl_bit(bench_idx(a)), 0, "R5");
      end
    end

    // R8 pass-all-multicast with zero table, then all-ones table in hash mode
    fill_table(32'h0);
    wr(8'h08, 32'h2, 32'hFFFF_FFFF);
    for (int k = 0; k < 32; k++) send({8'h33, 8'h33, 8'h00, 8'h00, 8'(k), 8'(k * 5)}, 1, 0, "R8");
    wr(8'h08, 32'h4, 32'hFFFF_FFFF);
    fill_table(32'hFFFF_FFFF);
    for (int k = 0; k < 32; k++) send({8'h33, 8'h33, 8'h00, 8'h00, 8'(k), 8'(k * 5)}, 1, 0, "R8");

    // R9 unicast under hash and all-multicast modes
    send(48'h020000000001, 0, 1, "R9");
    wr(8'h08, 32'h2, 32'hFFFF_FFFF);
    send(48'h001122334455, 0, 1, "R9");

    // R7 promiscuous (with pass-control companion)
    fill_table(32'h0);
    wr(8'h08, 32'h9, 32'hFFFF_FFFF);
    send(48'h001122334455, 1, 0, "R7");
    send(48'h01005E7F0001, 1, 0, "R7");

    // R10 broadcast
    wr(8'h08, 32'h0, 32'hFFFF_FFFF);
    send(48'hFFFFFFFFFFFF, 1, 0, "R10");
    wr(8'h08, 32'h10, 32'hFFFF_FFFF);
    send(48'hFFFFFFFFFFFF, 0, 0, "R10");
    wr(8'h08, 32'h12, 32'hFFFF_FFFF);
    send(48'hFFFFFFFFFFFF, 0, 0, "R10");
    send(48'hFFFFFFFFFFFE, 1, 0, "R10");
    wr(8'h08, 32'h11, 32'hFFFF_FFFF);
    send(48'hFFFFFFFFFFFF, 1, 0, "R10");

    // R6 strobe timing, gaps, trailing octets, restart
    wr(8'h08, 32'h2, 32'hFFFF_FFFF);
    chk(dec_valid == 0, "R6", 32'(dec_valid), 0);
    send(48'h010000000000, 1, 0, "R6");
    in_valid = 1; in_byte = 8'h55;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(dec_valid == 0, "R6 trailing", 32'(dec_valid), 0);
    end
    in_valid = 0; @(negedge clk);
    in_valid = 1; in_sof = 1; in_byte = 8'h01; @(negedge clk);
    in_sof = 0; in_byte = 8'h02; @(negedge clk);
    in_valid = 1; in_sof = 1; in_byte = 8'h02; @(negedge clk);
    in_sof = 0;
    for (int k = 0; k < 5; k++) begin
      in_valid = 0; @(negedge clk);
      chk(dec_valid == 0, "R6 gap", 32'(dec_valid), 0);
      in_valid = 1; in_byte = 8'(k); @(negedge clk);
    end
    in_valid = 0;
    chk({dec_valid, dec_accept, dec_unicast} == 3'b101, "R6 restart", 32'({dec_valid, dec_accept, dec_unicast}), 32'b101);
    @(negedge clk);
    chk(dec_valid == 0, "R6 pulse", 32'(dec_valid), 0);

    // R11 write coincident with the sixth octet
    wr(8'h08, 32'h4, 32'hFFFF_FFFF);
    a = 48'h01005E0A0B0C;
    for (int k = 0; k < 6; k++) begin
      in_valid = 1; in_sof = (k == 0); in_byte = a[47-8*k -: 8];
      if (k == 5) begin
        reg_we = 1; reg_addr = 8'h10 + 8'(4 * (bench_idx(a) / 32));
        reg_wdata = 32'hFFFF_FFFF; reg_wmask = 32'hFFFF_FFFF;
      end
      @(negedge clk);
    end
    in_valid = 0; in_sof = 0; reg_we = 0; reg_wmask = 0;
    chk({dec_valid, dec_accept} == 2'b10, "R11", 32'({dec_valid, dec_accept}), 32'b10);
    rd(8'h10 + 8'(4 * (bench_idx(a) / 32)), 32'hFFFF_FFFF, "R11");
    send(a, 1, 0, "R11");

    finish_report();
  end
endmodule